// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in first-out buffer whose write side and read side run on separate clocks. A word enters on each write-clock edge that sees the write enable high, and leaves through a registered output on each read-clock edge that sees the read enable high. The output port drives data only while the output enable is high. The two clocks may be unrelated, or the same net may drive both for single-clock use.

Five status outputs report the fill level: empty, full, more-than-half-full, almost-empty and almost-full. Two offset registers set the almost thresholds, and both load on the write clock. A mode input picks how the two almost flags are produced. They are either registered in their own clock domain from the synchronized occupancy, or decoded combinationally from the live difference of the two pointers. A rewind input moves the read pointer back to location zero, so stored data can be read a second time. Depth is a parameter. The default is 1024 words, and 8192 or 16384 are the deep configurations. Pointers cross domains as Gray code through two-stage synchronizers.

Top module: `dcfifo_flags`

## Requirements
- R1: While `rst_ni` is low: `empty_no`=0, `full_no`=1, `half_o`=0, `almost_empty_no`=0, `almost_full_no`=1, output register 0. Both offsets hold `DEF_OFF`.
- R2: Words leave in the order they entered. Writing and reading each move one word per enabled edge of their own clock. The output register changes only on a read-clock edge that accepts a read.
- R3: A write while `full_no`=0 and a read while `empty_no`=0 are ignored. They move no pointer and alter no stored word.
- R4: `empty_no` is 0 while the read-side occupancy is zero. A write is seen by the read side after the second read-clock edge that follows the write edge.
- R5: `full_no` is 0 while the write-side occupancy equals `DEPTH`. A read is seen by the write side after the second write-clock edge that follows the read edge.
- R6: `half_o` is 1 while the write-side occupancy is greater than `DEPTH/2`.
- R7: With `flag_async_i`=0, `almost_empty_no` is registered on the read clock. It is 0 when the read-side occupancy before that edge was at most n, so n-1 remaining words keep it asserted.
- R8: With `flag_async_i`=0, `almost_full_no` is registered on the write clock. It is 0 when the write-side occupancy before that edge was at least `DEPTH`-m, and 1 at `DEPTH`-(m+1) or fewer.
- R9: With `flag_async_i`=1, both almost flags are decoded combinationally from the live write pointer minus the live read pointer. They use the same thresholds and have no synchronizer or register delay.
- R10: A write-clock edge with `off_load_i`=1 loads `ae_off_i` into n and `af_off_i` into m.
- R11: A read-clock edge with `rewind_i`=1 sets the read pointer to location 0 and accepts no read. Later reads replay from the first word written since reset. This holds while fewer than `DEPTH` words have been written.
- R12: With `out_en_i`=0, `rd_data_o` is high impedance. The held output word is kept and reappears when the enable returns.
- R13: With unrelated write and read clocks, every word written is delivered once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | write clock |
| rclk_i | input | 1 | read clock |
| rst_ni | input | 1 | asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | write enable |
| wr_data_i | input | DW | word to store |
| rd_en_i | input | 1 | read enable |
| rewind_i | input | 1 | rewind the read pointer to location 0 (read clock) |
| out_en_i | input | 1 | output drive enable |
| flag_async_i | input | 1 | 0: registered almost flags, 1: combinational almost flags |
| off_load_i | input | 1 | load both offsets (write clock) |
| ae_off_i | input | PW | almost-empty offset n |
| af_off_i | input | PW | almost-full offset m |
| rd_data_o | output | DW | registered read word, high impedance when disabled |
| empty_no | output | 1 | empty, active low |
| full_no | output | 1 | full, active low |
| half_o | output | 1 | more than half full |
| almost_empty_no | output | 1 | almost empty, active low |
| almost_full_no | output | 1 | almost full, active low |

## Verification
A behavioural reference model runs beside the design on a shared clock and follows the two-edge synchronizer delay. It is compared on every cycle while the block is filled to the top, written while full, read while empty, read and written together at full, and drained to empty. The fill and drain walk every flag threshold, both before and after the offsets are reloaded. Runs in both flag modes show the one-edge registered lag of the synchronous flags against the combinational ones. A rewind replay shows the read pointer restart. Disabled-output reads show that the high-impedance state does not disturb the held word. A final pass with unrelated clocks checks order and completeness across a real clock crossing.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {
    FLAG_REGD = 1'b0,
    FLAG_COMB = 1'b1
  } flag_mode_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dcfifo_gray_sync.sv
module dcfifo_gray_sync #(
  parameter int W      = 11,
  parameter int STAGES = dcfifo_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             bin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  always_comb begin
    bin[W-1] = stg_q[STAGES-1][W-1];
    for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ stg_q[STAGES-1][i];
  end

  assign bin_o = bin;
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DW = 18,
  parameter int AW = 10
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side #(
  parameter int AW      = 10,
  parameter int DEF_OFF = 127,
  localparam int PW     = AW + 1,
  localparam int DEPTH  = 1 << AW
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          flag_comb_i,
  input  logic          off_load_i,
  input  logic [PW-1:0] ae_off_i,
  input  logic [PW-1:0] af_off_i,
  input  logic [PW-1:0] rbin_sync_i,
  input  logic [PW-1:0] rbin_live_i,
  output logic          push_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic [PW-1:0] ae_off_o,
  output logic          full_no,
  output logic          half_o,
  output logic          almost_full_no
);
  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt;
  logic [PW-1:0] ae_q, af_q;
  logic [PW-1:0] occ_w, occ_live;
  logic          full, hit_w, hit_live, paf_n_q;

  assign occ_w    = wbin_q - rbin_sync_i;
  assign occ_live = wbin_q - rbin_live_i;
  assign full     = (occ_w == PW'(DEPTH));
  assign push_o   = wr_en_i & ~full;
  assign wbin_nxt = wbin_q + PW'(push_o);

  // threshold DEPTH-m expressed as occ+m >= DEPTH to avoid underflow
  assign hit_w    = ({1'b0, occ_w}    + {1'b0, af_q}) >= (PW+1)'(DEPTH);
  assign hit_live = ({1'b0, occ_live} + {1'b0, af_q}) >= (PW+1)'(DEPTH);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      paf_n_q <= 1'b1;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      paf_n_q <= ~hit_w;
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q <= PW'(DEF_OFF);
      af_q <= PW'(DEF_OFF);
    end else if (off_load_i) begin
      ae_q <= ae_off_i;
      af_q <= af_off_i;
    end
  end

  assign wbin_o         = wbin_q;
  assign wgray_o        = wgray_q;
  assign ae_off_o       = ae_q;
  assign full_no        = ~full;
  assign half_o         = occ_w > PW'(DEPTH / 2);
  assign almost_full_no = flag_comb_i ? ~hit_live : paf_n_q;
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side #(
  parameter int AW  = 10,
  localparam int PW = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          rewind_i,
  input  logic          flag_comb_i,
  input  logic [PW-1:0] ae_off_i,
  input  logic [PW-1:0] wbin_sync_i,
  input  logic [PW-1:0] wbin_live_i,
  output logic          pop_o,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_no,
  output logic          almost_empty_no
);
  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt;
  logic [PW-1:0] occ_r, occ_live;
  logic          empty, pae_n_q;

  assign occ_r    = wbin_sync_i - rbin_q;
  assign occ_live = wbin_live_i - rbin_q;
  assign empty    = (occ_r == '0);
  assign pop_o    = rd_en_i & ~empty & ~rewind_i;
  assign rbin_nxt = rewind_i ? '0 : rbin_q + PW'(pop_o);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      pae_n_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      pae_n_q <= ~(occ_r <= ae_off_i);
    end
  end

  assign rbin_o          = rbin_q;
  assign rgray_o         = rgray_q;
  assign empty_no        = ~empty;
  assign almost_empty_no = flag_comb_i ? ~(occ_live <= ae_off_i) : pae_n_q;
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DW      = 18,
  parameter int DEPTH   = 1024,
  parameter int DEF_OFF = 127,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          rewind_i,
  input  logic          out_en_i,
  input  logic          flag_async_i,
  input  logic          off_load_i,
  input  logic [PW-1:0] ae_off_i,
  input  logic [PW-1:0] af_off_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_o,
  output logic          almost_empty_no,
  output logic          almost_full_no
);
  import dcfifo_pkg::*;

  logic [PW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s, ae_off;
  logic          push, pop, flag_comb;
  logic [DW-1:0] rdata;

  assign flag_comb = (flag_mode_e'(flag_async_i) == FLAG_COMB);

  dcfifo_wr_side #(.AW(AW), .DEF_OFF(DEF_OFF)) u_wr (
    .wclk_i        (wclk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .flag_comb_i   (flag_comb),
    .off_load_i    (off_load_i),
    .ae_off_i      (ae_off_i),
    .af_off_i      (af_off_i),
    .rbin_sync_i   (rbin_s),
    .rbin_live_i   (rbin),
    .push_o        (push),
    .wbin_o        (wbin),
    .wgray_o       (wgray),
    .ae_off_o      (ae_off),
    .full_no       (full_no),
    .half_o        (half_o),
    .almost_full_no(almost_full_no)
  );

  dcfifo_rd_side #(.AW(AW)) u_rd (
    .rclk_i         (rclk_i),
    .rst_ni         (rst_ni),
    .rd_en_i        (rd_en_i),
    .rewind_i       (rewind_i),
    .flag_comb_i    (flag_comb),
    .ae_off_i       (ae_off),
    .wbin_sync_i    (wbin_s),
    .wbin_live_i    (wbin),
    .pop_o          (pop),
    .rbin_o         (rbin),
    .rgray_o        (rgray),
    .empty_no       (empty_no),
    .almost_empty_no(almost_empty_no)
  );

  dcfifo_gray_sync #(.W(PW)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wgray),
    .bin_o (wbin_s)
  );

  dcfifo_gray_sync #(.W(PW)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rgray),
    .bin_o (rbin_s)
  );

  dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (push),
    .waddr_i(wbin[AW-1:0]),
    .wdata_i(wr_data_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (pop),
    .raddr_i(rbin[AW-1:0]),
    .rdata_o(rdata)
  );

  assign rd_data_o = out_en_i ? rdata : {DW{1'bz}};
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int PW = 11
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          rewind_i,
  input logic          empty_no,
  input logic          full_no,
  input logic          half_o,
  input logic [PW-1:0] wr_bin,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_bin,
  input logic [PW-1:0] rd_gray
);
  a_r3_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wr_bin));

  a_r3_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && !rewind_i) |=> $stable(rd_bin));

  a_r2_wptr_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !$stable(wr_bin) |-> ((wr_bin - $past(wr_bin)) == PW'(1)));

  a_r4_wgray_one_bit: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  a_r6_full_implies_half: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> half_o);

  a_r11_rewind_zero: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rewind_i |=> (rd_bin == '0));

  a_r11_rgray_one_bit: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rewind_i |=> ($countones(rd_gray ^ $past(rd_gray)) <= 1));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.PW(PW)) chk_i (
  .wclk_i  (wclk_i),
  .rclk_i  (rclk_i),
  .rst_ni  (rst_ni),
  .rewind_i(rewind_i),
  .empty_no(empty_no),
  .full_no (full_no),
  .half_o  (half_o),
  .wr_bin  (wbin),
  .wr_gray (wgray),
  .rd_bin  (rbin),
  .rd_gray (rgray)
);

// File: tb/dcfifo_flags_tb_top.sv
`timescale 1ns/1ps
module dcfifo_flags_tb_top;
  localparam int DW = 18, DEPTH = 64, PW = 7, M2 = 128, DOFF = 7;

  logic wclk = 1'b0, rclk_free = 1'b0, tied = 1'b1, rclk;
  always #2 wclk = ~wclk;
  always #3 rclk_free = ~rclk_free;
  assign rclk = tied ? wclk : rclk_free;

  logic rst_n, wen, ren, rt, oe, smode, ld;
  logic [DW-1:0] d;
  logic [PW-1:0] aeo, afo;
  wire  [DW-1:0] q;
  logic empty_n, full_n, half, pae_n, paf_n;

  dcfifo_flags #(.DW(DW), .DEPTH(DEPTH), .DEF_OFF(DOFF)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wen), .wr_data_i(d), .rd_en_i(ren), .rewind_i(rt),
    .out_en_i(oe), .flag_async_i(smode), .off_load_i(ld),
    .ae_off_i(aeo), .af_off_i(afo), .rd_data_o(q),
    .empty_no(empty_n), .full_no(full_n), .half_o(half),
    .almost_empty_no(pae_n), .almost_full_no(paf_n));

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_w, m_r, ws1, ws2, rs1, rs2, m_n, m_m;
  bit m_pae, m_paf;
  logic [DW-1:0] m_q;
  logic [DW-1:0] m_mem [DEPTH];

  function automatic int md(int x);
    return ((x % M2) + M2) % M2;
  endfunction

  task automatic m_reset();
    m_w = 0; m_r = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
    m_n = DOFF; m_m = DOFF; m_pae = 0; m_paf = 1; m_q = '0;
  endtask

  task automatic chk(string tag, string nm, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, bit w, logic [DW-1:0] dd, bit r, bit rtx, bit o, bit l);
    int cr, cw, raw;
    bit wok, rok, npae, npaf;
    wen = w; d = dd; ren = r; rt = rtx; oe = o; ld = l;
    @(posedge wclk);
    cr = md(ws2 - m_r); cw = md(m_w - rs2);
    wok = w && (cw != DEPTH);
    rok = r && (cr != 0) && !rtx;
    npae = !(cr <= m_n);
    npaf = !(cw + m_m >= DEPTH);
    if (rok) m_q = m_mem[m_r % DEPTH];
    if (wok) m_mem[m_w % DEPTH] = dd;
    ws2 = ws1; ws1 = m_w; rs2 = rs1; rs1 = m_r;
    m_w = md(m_w + int'(wok));
    m_r = rtx ? 0 : md(m_r + int'(rok));
    m_pae = npae; m_paf = npaf;
    if (l) begin m_n = int'(aeo); m_m = int'(afo); end
    @(negedge wclk);
    raw = md(m_w - m_r);
    chk(tag, "empty_no", empty_n, md(ws2 - m_r) != 0);
    chk(tag, "full_no", full_n, md(m_w - rs2) != DEPTH);
    chk(tag, "half_o", half, md(m_w - rs2) > DEPTH / 2);
    chk(tag, "almost_empty_no", pae_n, smode ? !(raw <= m_n) : m_pae);
    chk(tag, "almost_full_no", paf_n, smode ? !(raw + m_m >= DEPTH) : m_paf);
    if (o) chk(tag, "rd_data_o", q, m_q);
    else begin
      tests++;
      if (!(q === {DW{1'bz}} || q === '0)) begin
        fails++;
        $display("FAIL %s rd_data_o not released actual=%h expected=z", tag, q);
      end
    end
  endtask

  task automatic wr(string tag, logic [DW-1:0] dd); cyc(tag, 1, dd, 0, 0, 1, 0); endtask
  task automatic rd(string tag);                    cyc(tag, 0, '0, 1, 0, 1, 0); endtask
  task automatic idle(string tag);                  cyc(tag, 0, '0, 0, 0, 1, 0); endtask

  task automatic do_reset();
    rst_n = 0; wen = 0; ren = 0; rt = 0; ld = 0; oe = 1; d = '0;
    m_reset();
    @(negedge wclk); @(negedge wclk);
    rst_n = 1;
  endtask

  initial begin
    rst_n = 0; wen = 0; ren = 0; rt = 0; oe = 1; smode = 0; ld = 0;
    d = '0; aeo = '0; afo = '0;
    m_reset();
    repeat (3) @(negedge wclk);
    // R1 reset state
    chk("R1", "empty_no", empty_n, 0);
    chk("R1", "full_no", full_n, 1);
    chk("R1", "half_o", half, 0);
    chk("R1", "almost_empty_no", pae_n, 0);
    chk("R1", "almost_full_no", paf_n, 1);
    chk("R1", "rd_data_o", q, '0);
    rst_n = 1;
    repeat (3) idle("R1");

    // R4 visibility latency of one word
    wr("R4", 18'h00011);
    repeat (3) idle("R4");
    rd("R2"); idle("R2");

    // R2 ordered burst
    for (int i = 0; i < 10; i++) wr("R2", 18'h00100 + 18'(i));
    repeat (3) idle("R2");
    for (int i = 0; i < 10; i++) rd("R2");
    // R3 reads while empty
    repeat (2) rd("R3");
    repeat (2) idle("R3");

    // R10 reload offsets n=3, m=5
    aeo = 7'd3; afo = 7'd5;
    cyc("R10", 0, '0, 0, 0, 1, 1);
    idle("R10");

    // fill through half (R6), almost-full (R8) to full (R5)
    for (int i = 0; i < 40; i++) wr("R6", 18'h01000 + 18'(i));
    for (int i = 40; i < 64; i++) wr("R8", 18'h01000 + 18'(i));
    repeat (3) idle("R5");
    for (int i = 0; i < 3; i++) wr("R3", 18'h3ffff);
    for (int i = 0; i < 10; i++) cyc("R2", 1, 18'h02000 + 18'(i), 1, 0, 1, 0);
    for (int i = 0; i < 70; i++) rd("R7");
    repeat (3) idle("R7");

    // R9 combinational flag mode
    smode = 1;
    idle("R9");
    for (int i = 0; i < 6; i++) wr("R9", 18'h03000 + 18'(i));
    for (int i = 0; i < 8; i++) rd("R9");
    smode = 0;
    repeat (2) idle("R9");

    // R11 rewind replay
    do_reset();
    for (int i = 0; i < 5; i++) wr("R11", 18'h04000 + 18'(i));
    repeat (3) idle("R11");
    for (int i = 0; i < 3; i++) rd("R11");
    cyc("R11", 0, '0, 1, 1, 1, 0);
    for (int i = 0; i < 6; i++) rd("R11");

    // R12 output enable
    for (int i = 0; i < 2; i++) wr("R12", 18'h05000 + 18'(i));
    repeat (3) idle("R12");
    cyc("R12", 0, '0, 1, 0, 0, 0);
    cyc("R12", 0, '0, 0, 0, 0, 0);
    idle("R12");
    cyc("R12", 0, '0, 1, 0, 0, 0);
    idle("R12");

    // R13 unrelated clocks
    tied = 0;
    do_reset();
    fork
      begin
        int k = 0;
        while (k < 40) begin
          @(negedge wclk);
          if (full_n) begin wen = 1; d = 18'h06000 + 18'(k); k++; end
          else wen = 0;
        end
        @(negedge wclk); wen = 0;
      end
      begin
        int k = 0;
        bit pend = 0;
        while (k < 40) begin
          @(negedge rclk);
          if (pend) begin chk("R13", "rd_data_o", q, 18'h06000 + 18'(k)); k++; end
          pend = empty_n; ren = empty_n;
        end
        ren = 0;
      end
    join
    repeat (6) @(negedge rclk);
    chk("R13", "empty_no", empty_n, 0);
    chk("R13", "almost_empty_no", pae_n, 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule